// File: doc/BRIEF.md
# Fault Event Collector with Error Pin

The block gathers fault events from on-chip detectors, such as memory ECC checkers or the error output of a peer collector. Each event input is synchronized and caught on its rising edge into a sticky status bit, provided the event is enabled. An enabled event is assigned to one of two groups by a per-event priority bit. Each group drives its own interrupt: a low-priority one for faults that have already been corrected, and a high-priority one for faults that need immediate handling.

The same capture that raises an interrupt also pulls an active-low fault pin to ground. The pin works in one of two modes. In level mode it is high while the system is healthy. In toggle mode it carries a programmable high/low pattern while healthy, so that an external monitor can tell a dead device from a healthy one. In both modes a fault drives the pin to a constant low. A minimum hold time keeps the pin low even if software acknowledges the fault early.

A "monitored" control bit forces level mode, because a peer collector that watches this pin needs a plain level. The inverted pin of one instance can drive an event input of another instance. The fault then propagates only if that input is enabled in the receiving instance.

Top module: `fault_collector`

## Requirements
- R1: After synchronous reset, fault_n is 1, both interrupts are 0, and every register reads 0 (level mode, no events enabled).
- R2: A rising edge on an enabled evt_i bit sets the matching status bit, even for a one-cycle pulse. The bit stays set after the input falls.
- R3: An event whose enable bit is 0 sets no status bit, raises no interrupt and leaves fault_n high.
- R4: A captured event drives irq_lo when its priority bit is 0 and irq_hi when its priority bit is 1. Each interrupt is high while any status bit of its group is set.
- R5: An interrupt rises in the same clock cycle in which fault_n falls for the same event.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An interrupt drops once its group has no status bit set.
- R7: Once fault_n falls, it stays low for at least hold-register cycles. A clear request written before that time has passed is kept and takes effect when the time runs out, with no second write.
- R8: fault_n stays low while any high-priority status bit is set, even when a clear request is pending and the hold time has passed.
- R9: In toggle mode with no fault, fault_n repeats a pattern of exactly HI cycles high followed by LO cycles low (a count of 0 counts as 1).
- R10: In toggle mode, a fault drives fault_n to a constant low until the fault is released.
- R11: With the monitored bit set, toggle mode is ignored: a healthy fault_n is a steady 1.
- R12: Register map, by reg_addr:
  - 0: enable.
  - 1: priority, where 1 means high.
  - 2: status (write 1 to clear).
  - 3: control. Bit 0 selects toggle mode, bit 1 is the monitored bit, and bit 2 is a self-clearing clear request.
  - 4: hold cycles.
  - 5: HI count.
  - 6: LO count.
  
  reg_rdata shows the addressed register one cycle after reg_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_EVT | Asynchronous fault event inputs, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| irq_lo | output | 1 | Low-priority interrupt |
| irq_hi | output | 1 | High-priority interrupt |
| fault_n | output | 1 | Active-low external fault pin |

## Verification
The assertions check four properties on every cycle:
- Reset forces a quiet pin and quiet interrupts.
- A rising interrupt always comes with a low pin.
- Each low stretch of the pin lasts at least the programmed hold time.
- The pin is never released while a high-priority interrupt is up.

Only the directed scenarios can show the rest:
- The toggle pattern's exact high and low lengths.
- That a disabled event changes nothing.
- That a single-cycle pulse is captured.
- That an early clear request is honoured later with no second write.
- That the monitored bit overrides toggle mode.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [2:0] {
    A_ENABLE = 3'd0,
    A_PRIO   = 3'd1,
    A_STATUS = 3'd2,
    A_CTRL   = 3'd3,
    A_HOLD   = 3'd4,
    A_TGLHI  = 3'd5,
    A_TGLLO  = 3'd6
  } reg_addr_e;

  localparam int CTRL_TOGGLE = 0;
  localparam int CTRL_MON    = 1;
  localparam int CTRL_CLRREQ = 2;
endpackage

// File: rtl/fc_evt_sync.sv
module fc_evt_sync #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  output logic [N_EVT-1:0] rise_o
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= evt_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_o[i] = sync_q & ~prev_q;
  end
endmodule

// File: rtl/fc_hold_timer.sv
module fc_hold_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fc_pin_drv.sv
module fc_pin_drv #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toggle_on,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  input  logic             fault,
  output logic             pin_n
);
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hi_eff, lo_eff;

  assign hi_eff = (hi_len == '0) ? CNT_W'(1) : hi_len;
  assign lo_eff = (lo_len == '0) ? CNT_W'(1) : lo_len;

  always_ff @(posedge clk) begin
    if (rst || !toggle_on) begin
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (cnt_q == '0) begin
      phase_q <= ~phase_q;
      cnt_q   <= phase_q ? lo_eff - 1'b1 : hi_eff - 1'b1;
    end else begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            pin_n <= 1'b1;
    else if (fault)     pin_n <= 1'b0;
    else if (toggle_on) pin_n <= phase_q;
    else                pin_n <= 1'b1;
  end
endmodule

// File: rtl/fault_collector.sv
module fault_collector
  import fc_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int CNT_W = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_lo,
  output logic             irq_hi,
  output logic             fault_n
);
  logic [N_EVT-1:0] enable_q, prio_q, status_q;
  logic [N_EVT-1:0] rise, set_vec, w1c;
  logic [1:0]       ctrl_q;
  logic [CNT_W-1:0] hold_q, tglhi_q, tgllo_q;
  logic             set_any, clr_req, clr_pend_q, err_act_q;
  logic             expired, hi_pending, release_now, toggle_on;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  fc_evt_sync #(.N_EVT(N_EVT)) u_sync (
    .clk(clk), .rst(rst), .evt_i(evt_i), .rise_o(rise)
  );

  assign set_vec = rise & enable_q;
  assign set_any = |set_vec;
  assign w1c     = (reg_we && reg_addr == A_STATUS) ? reg_wdata[N_EVT-1:0] : '0;
  assign clr_req = reg_we && reg_addr == A_CTRL && reg_wdata[CTRL_CLRREQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      prio_q   <= '0;
      ctrl_q   <= '0;
      hold_q   <= '0;
      tglhi_q  <= '0;
      tgllo_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_ENABLE: enable_q <= reg_wdata[N_EVT-1:0];
        A_PRIO:   prio_q   <= reg_wdata[N_EVT-1:0];
        A_CTRL:   ctrl_q   <= reg_wdata[1:0];
        A_HOLD:   hold_q   <= reg_wdata[CNT_W-1:0];
        A_TGLHI:  tglhi_q  <= reg_wdata[CNT_W-1:0];
        A_TGLLO:  tgllo_q  <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~w1c) | set_vec;
  end

  fc_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .load(set_any), .load_val(hold_q), .expired(expired)
  );

  assign hi_pending  = |(status_q & prio_q);
  assign release_now = err_act_q && clr_pend_q && expired && !hi_pending && !set_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_act_q  <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      if (set_any)          err_act_q <= 1'b1;
      else if (release_now) err_act_q <= 1'b0;

      if (set_any || release_now) clr_pend_q <= 1'b0;
      else if (clr_req)           clr_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= |(status_q & ~prio_q);
      irq_hi <= hi_pending;
    end
  end

  assign toggle_on = ctrl_q[CTRL_TOGGLE] & ~ctrl_q[CTRL_MON];

  fc_pin_drv #(.CNT_W(CNT_W)) u_pin (
    .clk(clk), .rst(rst), .toggle_on(toggle_on), .hi_len(tglhi_q),
    .lo_len(tgllo_q), .fault(err_act_q), .pin_n(fault_n)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_ENABLE: reg_rdata <= DW'(enable_q);
        A_PRIO:   reg_rdata <= DW'(prio_q);
        A_STATUS: reg_rdata <= DW'(status_q);
        A_CTRL:   reg_rdata <= DW'(ctrl_q);
        A_HOLD:   reg_rdata <= DW'(hold_q);
        A_TGLHI:  reg_rdata <= DW'(tglhi_q);
        A_TGLLO:  reg_rdata <= DW'(tgllo_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fault_n,
  input logic             irq_lo,
  input logic             irq_hi,
  input logic [CNT_W-1:0] hold_cycles
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || fault_n) low_run <= '0;
    else                low_run <= low_run + 1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (fault_n && !irq_lo && !irq_hi));

  // R5
  irq_with_pin_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_lo) || $rose(irq_hi)) |-> !fault_n);

  // R7
  min_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> (low_run >= 32'(hold_cycles)));

  // R8
  hi_blocks_release_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && !fault_n) |=> !fault_n);
endmodule

bind fault_collector fc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fault_n(fault_n), .irq_lo(irq_lo),
  .irq_hi(irq_hi), .hold_cycles(hold_q)
);

// File: tb/sim_fault_collector.sv
`timescale 1ns/1ps
module sim_fault_collector;
  localparam int N_EVT = 8;
  localparam int DW    = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_EVT-1:0] evt_i = '0;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [DW-1:0]    reg_wdata = '0;
  logic [DW-1:0]    reg_rdata;
  logic             irq_lo, irq_hi, fault_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fault_collector u0 (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lo(irq_lo),
    .irq_hi(irq_hi), .fault_n(fault_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(addr); reg_wdata = DW'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    reg_addr = 3'(addr);
    @(negedge clk);
    data = int'(reg_rdata);
  endtask

  task automatic pulse(input int bitn);
    @(negedge clk);
    evt_i[bitn] = 1'b1;
    @(negedge clk);
    evt_i[bitn] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    chk(fault_n === 1'b1, "R1 fault_n", fault_n, 1);
    chk(irq_lo === 1'b0 && irq_hi === 1'b0, "R1 irqs", {irq_hi, irq_lo}, 0);
    rd(2, v); chk(v == 0, "R1 status", v, 0);
    rd(3, v); chk(v == 0, "R1 ctrl", v, 0);
  endtask

  task automatic t_disabled();
    int v;
    wr(4, 4);
    wr(0, 8'hF7);
    pulse(3); idle(8);
    chk(fault_n === 1'b1, "R3 pin", fault_n, 1);
    chk(irq_lo === 1'b0 && irq_hi === 1'b0, "R3 irqs", {irq_hi, irq_lo}, 0);
    rd(2, v); chk(v == 0, "R3 status", v, 0);
  endtask

  task automatic t_low_event();
    int v; int sync_ok = 0;
    wr(0, 8'hFF);
    wr(1, 8'hF0);
    pulse(1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (irq_lo || !fault_n) begin
        sync_ok = (irq_lo && !fault_n) ? 1 : 0;
        break;
      end
    end
    chk(sync_ok == 1, "R5 irq and pin together", sync_ok, 1);
    idle(2);
    rd(2, v); chk(v == 2, "R2 sticky status after pulse", v, 2);
    chk(irq_lo === 1'b1 && irq_hi === 1'b0, "R4 low group", {irq_hi, irq_lo}, 1);
    wr(2, 1);
    rd(2, v); chk(v == 2, "R6 write of other bit keeps status", v, 2);
    wr(2, 2); idle(2);
    rd(2, v); chk(v == 0, "R6 w1c clears", v, 0);
    chk(irq_lo === 1'b0, "R6 irq_lo drops", irq_lo, 0);
    wr(3, 4); idle(10);
    chk(fault_n === 1'b1, "R7 release after clear", fault_n, 1);
  endtask

  task automatic t_min_hold();
    wr(4, 40);
    pulse(0); idle(6);
    wr(2, 1);
    wr(3, 4);
    idle(15);
    chk(fault_n === 1'b0, "R7 still low before hold time", fault_n, 0);
    idle(40);
    chk(fault_n === 1'b1, "R7 clear honoured at expiry", fault_n, 1);
  endtask

  task automatic t_hi_block();
    int v;
    wr(4, 4);
    pulse(5); idle(6);
    chk(irq_hi === 1'b1 && irq_lo === 1'b0, "R4 high group", {irq_hi, irq_lo}, 2);
    wr(3, 4); idle(20);
    chk(fault_n === 1'b0, "R8 held by high status", fault_n, 0);
    wr(2, 32);
    idle(5);
    chk(fault_n === 1'b1, "R8 release once high clear", fault_n, 1);
    rd(2, v); chk(v == 0, "R6 high status cleared", v, 0);
  endtask

  task automatic t_toggle();
    int hi_run = 0; int lo_run = 0; int g = 0;
    wr(5, 3); wr(6, 5); wr(3, 1);
    while (fault_n !== 1'b0 && g < 100) begin @(negedge clk); g++; end
    while (fault_n !== 1'b1 && g < 100) begin @(negedge clk); g++; end
    while (fault_n === 1'b1 && g < 100) begin hi_run++; @(negedge clk); g++; end
    while (fault_n === 1'b0 && g < 100) begin lo_run++; @(negedge clk); g++; end
    chk(hi_run == 3, "R9 high length", hi_run, 3);
    chk(lo_run == 5, "R9 low length", lo_run, 5);
  endtask

  task automatic t_toggle_fault();
    int highs = 0;
    pulse(2); idle(6);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (fault_n !== 1'b0) highs++;
    end
    chk(highs == 0, "R10 constant low under fault", highs, 0);
    wr(2, 4); wr(3, 5); idle(12);
  endtask

  task automatic t_monitored();
    int lows = 0;
    wr(3, 3); idle(3);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (fault_n !== 1'b1) lows++;
    end
    chk(lows == 0, "R11 steady high when monitored", lows, 0);
    pulse(4); idle(6);
    chk(fault_n === 1'b0, "R11 level fault low", fault_n, 0);
  endtask

  task automatic t_regs();
    int v;
    wr(1, 8'hA5);
    rd(1, v); chk(v == 8'hA5, "R12 priority readback", v, 8'hA5);
    wr(4, 16'h1234);
    rd(4, v); chk(v == 16'h1234, "R12 hold readback", v, 16'h1234);
    rd(3, v); chk(v == 3, "R12 ctrl clear bit self-clears", v, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    idle(2);
    t_reset();
    t_disabled();
    t_low_event();
    t_min_hold();
    t_hi_block();
    t_toggle();
    t_toggle_fault();
    t_monitored();
    t_regs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule